// File: doc/BRIEF.md
# Quad Digital Potentiometer Serial Control

This block is the control logic behind a four-channel, 64-position variable resistor. A host drives a three-wire serial link (active-low select, serial clock, serial data). Each transfer carries one 8-bit command. The top two bits address a channel and the low six bits are the wiper code for that channel. When the select line is released after exactly eight bits, the block writes the code into the addressed channel latch. All other latches keep their values. Channels may be written one at a time in any order.

The three serial inputs, the preset input and the shutdown input arrive asynchronously. They pass through two-flop synchronizers into the system clock domain. A preset request, or the synchronous system reset, returns every latch to midscale (code 32). A shutdown request raises a per-channel flag meaning "terminal A open, wiper tied to B". The latch contents stay untouched, so the programmed codes are still there when shutdown is released. Each accepted write produces a one-cycle strobe on the written channel.

Top module: `dpot_ctrl`

## Requirements
- R1: A frame is 8 bits sampled MSB first on rising `sclk` edges while `cs_n` is low. Bits [7:6] are the channel address and bits [5:0] are the code. On the rising edge of `cs_n` the addressed channel's code output (`wiper_o[ch*6 +: 6]`) takes that code.
- R2: A write changes only the addressed channel; the other three codes are unchanged.
- R3: Every code from 0 to 63 is stored exactly, including the extremes 0 and 63.
- R4: While `rst` is high every channel code becomes 32, every shutdown flag is 0 and no strobe is raised.
- R5: A high level on `preset` sets every channel code to 32.
- R6: While `preset` is high, a frame that completes does not change any code and raises no strobe.
- R7: While `shdn` is high, all four `shut_o` flags are 1 and the codes keep their values.
- R8: After `shdn` falls, the flags return to 0 and the codes equal those programmed before shutdown.
- R9: A frame of any bit count other than 8 is discarded: no code changes and no strobe.
- R10: Each accepted frame raises exactly one bit of `wr_stb_o`, the bit of the addressed channel, for exactly one system clock cycle.
- R11: A written code is not yet visible 3 system clock edges after `cs_n` rises, and is visible after 4 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; loads midscale |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data, asynchronous |
| preset | input | 1 | Asynchronous request to load midscale in every channel |
| shdn | input | 1 | Asynchronous shutdown request |
| wiper_o | output | N_CH*CODE_W | Packed wiper codes, channel 0 in the low bits |
| shut_o | output | N_CH | Per-channel shutdown flag (A open, wiper to B) |
| wr_stb_o | output | N_CH | One-cycle strobe per channel on each accepted write |

## Verification
The bench builds the block with its default parameters: four channels and 6-bit codes. With these values the whole code range fits in a short table, so both extremes (0 and 63) and the midscale value are reached directly. With four channels, every address value is exercised and the untouched neighbours of each write can be compared against a model. The serial clock runs at one eighth of the system clock rate. This makes the synchronizer latency observable edge by edge, and lets preset and shutdown be held across complete frames.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int DEF_N_CH   = 4;
    localparam int DEF_CODE_W = 6;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        LNK_IDLE  = 2'd0,
        LNK_SHIFT = 2'd1,
        LNK_DONE  = 2'd2
    } lnk_state_e;

    function automatic int addr_width(input int n_ch);
        return (n_ch > 1) ? $clog2(n_ch) : 1;
    endfunction

    function automatic int frame_width(input int n_ch, input int code_w);
        return addr_width(n_ch) + code_w;
    endfunction

    function automatic logic [31:0] mid_code(input int code_w);
        return 32'd1 << (code_w - 1);
    endfunction

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dpot_shifter.sv
module dpot_shifter
    import dpot_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               sdi_s,
    output logic               frm_vld_o,
    output logic [FRAME_W-1:0] frm_o
);
    localparam int            CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sclk_d, cs_d;
    lnk_state_e         st_q;
    logic               sclk_rise, cs_rise;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign cs_rise   = cs_n_s & ~cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            cs_d      <= 1'b1;
            sh_q      <= '0;
            cnt_q     <= '0;
            st_q      <= LNK_IDLE;
            frm_vld_o <= 1'b0;
            frm_o     <= '0;
        end else begin
            sclk_d    <= sclk_s;
            cs_d      <= cs_n_s;
            frm_vld_o <= 1'b0;
            if (cs_n_s) begin
                cnt_q <= '0;
                st_q  <= LNK_IDLE;
                if (cs_rise && st_q == LNK_DONE && cnt_q == CNT_END) begin
                    frm_vld_o <= 1'b1;
                    frm_o     <= sh_q;
                end
            end else if (sclk_rise) begin
                sh_q <= {sh_q[FRAME_W-2:0], sdi_s};
                if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
                st_q <= (cnt_q == CNT_END - 1'b1) ? LNK_DONE : LNK_SHIFT;
            end
        end
    end
endmodule

// File: rtl/dpot_bank.sv
module dpot_bank
    import dpot_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int CODE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     preset_s,
    input  logic                     wr_en,
    input  logic [addr_width(N_CH)-1:0] wr_addr,
    input  logic [CODE_W-1:0]        wr_code,
    output logic [N_CH*CODE_W-1:0]   codes_o,
    output logic [N_CH-1:0]          stb_o
);
    localparam int          ADDR_W = addr_width(N_CH);
    localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

    genvar i;
    generate
        for (i = 0; i < N_CH; i++) begin : g_ch
            logic [CODE_W-1:0] lat_q;
            logic              hit;
            assign hit = wr_en && (wr_addr == ADDR_W'(i));
            always_ff @(posedge clk) begin
                if (rst || preset_s) begin
                    lat_q    <= MID;
                    stb_o[i] <= 1'b0;
                end else begin
                    stb_o[i] <= hit;
                    if (hit) begin
                        lat_q <= wr_code;
                    end
                end
            end
            assign codes_o[i*CODE_W +: CODE_W] = lat_q;
        end
    endgenerate
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int N_CH   = DEF_N_CH,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   sclk,
    input  logic                   sdi,
    input  logic                   preset,
    input  logic                   shdn,
    output logic [N_CH*CODE_W-1:0] wiper_o,
    output logic [N_CH-1:0]        shut_o,
    output logic [N_CH-1:0]        wr_stb_o
);
    localparam int ADDR_W  = addr_width(N_CH);
    localparam int FRAME_W = frame_width(N_CH, CODE_W);

    logic [4:0]         raw_in, syn_q;
    logic               cs_s, sclk_s, sdi_s, pre_s, shdn_s;
    logic               frm_vld;
    logic [FRAME_W-1:0] frm;

    assign raw_in = {cs_n, sclk, sdi, preset, shdn};

    dpot_sync #(
        .W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b10000)
    ) u_sync (
        .clk(clk), .rst(rst), .d_i(raw_in), .q_o(syn_q)
    );

    assign {cs_s, sclk_s, sdi_s, pre_s, shdn_s} = syn_q;

    dpot_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst(rst),
        .cs_n_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .frm_vld_o(frm_vld), .frm_o(frm)
    );

    dpot_bank #(.N_CH(N_CH), .CODE_W(CODE_W)) u_bank (
        .clk(clk), .rst(rst), .preset_s(pre_s),
        .wr_en(frm_vld),
        .wr_addr(frm[FRAME_W-1 -: ADDR_W]),
        .wr_code(frm[CODE_W-1:0]),
        .codes_o(wiper_o),
        .stb_o(wr_stb_o)
    );

    assign shut_o = {N_CH{shdn_s}};
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
    parameter int N_CH   = 4,
    parameter int CODE_W = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   pre_s,
    input logic [N_CH*CODE_W-1:0] codes,
    input logic [N_CH-1:0]        flags,
    input logic [N_CH-1:0]        stb
);
    localparam logic [CODE_W-1:0]      MID     = CODE_W'(1 << (CODE_W - 1));
    localparam logic [N_CH*CODE_W-1:0] ALL_MID = {N_CH{MID}};

    p_stb_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));

    p_stb_single_r10: assert property (@(posedge clk) disable iff (rst)
        (stb != '0) |=> (stb == '0));

    p_preset_mid_r5: assert property (@(posedge clk) disable iff (rst)
        pre_s |=> (codes == ALL_MID));

    p_preset_nostb_r6: assert property (@(posedge clk) disable iff (rst)
        pre_s |=> (stb == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (stb == '0 && !$past(pre_s)) |-> (codes == $past(codes)));

    p_flags_uniform_r7: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) || (flags == '1));
endmodule

bind dpot_ctrl dpot_ctrl_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst(rst), .pre_s(pre_s),
    .codes(wiper_o), .flags(shut_o), .stb(wr_stb_o)
);

// File: tb/sim_dpot_ctrl.sv
module sim_dpot_ctrl;
    localparam int NC = 4;
    localparam int CW = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, preset = 1'b0, shdn = 1'b0;
    logic [NC*CW-1:0] wiper_o;
    logic [NC-1:0]    shut_o, wr_stb_o;

    int total = 0, bad = 0, cyc = 0;
    int stb_cnt [NC];
    int stb_bad = 0;
    int model [NC];

    always #4 clk = ~clk;

    dpot_ctrl #(.N_CH(NC), .CODE_W(CW)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .preset(preset), .shdn(shdn),
        .wiper_o(wiper_o), .shut_o(shut_o), .wr_stb_o(wr_stb_o)
    );

    // address in [7:6], code in [5:0]
    localparam logic [7:0] VEC [10] = '{
        8'b00_000000, 8'b11_111111, 8'b10_010101, 8'b01_101010,
        8'b11_000001, 8'b00_111110, 8'b01_100000, 8'b10_000000,
        8'b10_111111, 8'b00_011011
    };

    initial for (int k = 0; k < NC; k++) stb_cnt[k] = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if ($countones(wr_stb_o) > 1) stb_bad++;
            for (int k = 0; k < NC; k++) if (wr_stb_o[k]) stb_cnt[k]++;
        end
    end

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input int ch);
        return int'(wiper_o[ch*CW +: CW]);
    endfunction

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] v, input int nb);
        cs_n = 1'b0;
        waitn(3);
        for (int b = nb - 1; b >= 0; b--) begin
            sdi = v[b];
            waitn(4);
            sclk = 1'b1;
            waitn(4);
            sclk = 1'b0;
        end
        waitn(3);
        cs_n = 1'b1;
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < NC; k++) chk(code_of(k), model[k], req);
    endtask

    task automatic check_stb(input int exp [NC], input string req);
        for (int k = 0; k < NC; k++) chk(stb_cnt[k], exp[k], req);
    endtask

    initial begin
        int exp_stb [NC];
        for (int k = 0; k < NC; k++) begin model[k] = 32; exp_stb[k] = 0; end
        waitn(4);
        // R4: reset state
        check_all("R4");
        chk(int'(shut_o), 0, "R4");
        chk(int'(wr_stb_o), 0, "R4");
        rst = 1'b0;
        waitn(4);

        // R1 R2 R3 R10: table walk
        for (int v = 0; v < 10; v++) begin
            shift_bits({8'h00, VEC[v]}, 8);
            waitn(8);
            model[VEC[v][7:6]] = int'(VEC[v][5:0]);
            exp_stb[VEC[v][7:6]]++;
            check_all("R1 R2 R3");
            check_stb(exp_stb, "R10");
        end
        chk(stb_bad, 0, "R10");

        // R11: latency of a write
        shift_bits(16'h0005, 8);
        waitn(3);
        chk(code_of(0), model[0], "R11");
        waitn(1);
        model[0] = 5;
        exp_stb[0]++;
        chk(code_of(0), 5, "R11");
        waitn(6);

        // R9: short and long frames discarded
        shift_bits(16'h007F, 7);
        waitn(8);
        check_all("R9");
        shift_bits(16'h01C0, 9);
        waitn(8);
        check_all("R9");
        check_stb(exp_stb, "R9");

        // R7 R8: shutdown keeps codes and restores them
        shdn = 1'b1;
        waitn(4);
        chk(int'(shut_o), 15, "R7");
        check_all("R7");
        waitn(20);
        check_all("R7");
        shdn = 1'b0;
        waitn(4);
        chk(int'(shut_o), 0, "R8");
        check_all("R8");

        // R6: preset held across a complete frame
        preset = 1'b1;
        waitn(4);
        shift_bits(16'h0081, 8);
        waitn(8);
        for (int k = 0; k < NC; k++) model[k] = 32;
        check_all("R6");
        check_stb(exp_stb, "R6");
        preset = 1'b0;
        waitn(4);

        // R5: preset pulse after new writes
        shift_bits(16'h00C3, 8);
        waitn(8);
        model[3] = 3;
        exp_stb[3]++;
        check_all("R1");
        preset = 1'b1;
        waitn(4);
        preset = 1'b0;
        waitn(4);
        model[3] = 32;
        check_all("R5");

        // R4: reset mid-run
        shift_bits(16'h0047, 8);
        waitn(8);
        exp_stb[1]++;
        rst = 1'b1;
        waitn(2);
        check_all("R4");
        chk(int'(wr_stb_o), 0, "R4");
        rst = 1'b0;
        waitn(4);
        check_stb(exp_stb, "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule